// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block owns the exception-related fields of a 32-bit floating-point status word. An arithmetic unit presents a valid strobe together with five raw IEEE exception flags for each completed operation. The block stores those flags as the current-exception field and compares them with the trap-enable field. If any flag is also enabled, the block raises a one-cycle trap request and records the IEEE-exception trap type. If no flag is enabled, the block ORs the flags into the accrued field, which collects exceptions over many operations.

A load port replaces the status word. Only the writable bits take the new value. The other bits keep their old value, except the trap-type field, which a load clears. The two-bit rounding-mode field is always decoded onto a one-hot select for the datapath. Operations that cannot raise exceptions, such as integer-to-double conversion, do not drive the strobe and leave the word untouched.

Top module: `fsr_trap_unit`

## Requirements
- R1: After synchronous reset, `status` is 0, `trap_req` is 0 and `rnd_sel` is 4'b0001 (round to nearest-even).
- R2: An accepted operation (`op_valid` high, `ld_valid` low) replaces bits 4:0 of `status` with `op_flags` in the cycle after the strobe. The flag order is invalid at bit 4, overflow at bit 3, underflow at bit 2, divide-by-zero at bit 1 and inexact at bit 0.
- R3: The trap-enable field sits at bits 27:23, so enable bit 23+i guards flag bit i. When an accepted operation has `op_flags & status[27:23]` nonzero, `trap_req` is high for exactly the next cycle and bits 16:14 become 3'b001.
- R4: A trapping operation leaves the accrued field, bits 9:5, unchanged.
- R5: A non-trapping accepted operation ORs `op_flags` into bits 9:5. Flag bit i maps to bit 5+i.
- R6: The trap-type field, bits 16:14, holds its value through later operations and idle cycles until the next load, which writes it to 0.
- R7: A load sets `status` to `(ld_data & WR_MASK) | (old & ~WR_MASK)`, with bits 16:14 forced to 0. The default WR_MASK is 32'hCF80_03FF: bits 31:30, 27:23 and 9:0.
- R8: `rnd_sel` is one-hot and decodes bits 31:30 of `status` as follows: 0 gives nearest-even (bit 0), 1 gives toward zero (bit 1), 2 gives toward +infinity (bit 2) and 3 gives toward -infinity (bit 3).
- R9: When `ld_valid` and `op_valid` are high in the same cycle, the load wins. The operation's flags are dropped and no trap is raised.
- R10: An accepted operation with all-zero flags clears bits 4:0 and raises no trap. A cycle with neither strobe leaves `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation-complete strobe |
| op_flags | input | 5 | Raw exception flags {invalid, overflow, underflow, div-by-zero, inexact} |
| ld_valid | input | 1 | Status-word load strobe |
| ld_data | input | 32 | New status word for a load |
| status | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle trap request |
| rnd_sel | output | 4 | One-hot rounding-mode select |

## Verification
The hardest case to reach from the ports is a trapping operation that arrives while the accrued field already holds a mix of set bits. Only then can the bench see a wrongly merged accrued field. The stimulus first loads random enable and accrued values. It then issues random flag patterns, so traps land on accrued fields that are partly filled. It also adds directed cases: consecutive traps, a load that collides with a trapping operation, and zero-flag operations.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int FSR_W    = 32;
    localparam int NFLAG    = 5;
    localparam int CEXC_LSB = 0;
    localparam int AEXC_LSB = CEXC_LSB + NFLAG;
    localparam int TEN_LSB  = 23;
    localparam int TT_LSB   = 14;
    localparam int TT_W     = 3;
    localparam int RND_LSB  = 30;
    localparam int RND_W    = 2;
    localparam int NMODE    = 1 << RND_W;

    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;
    localparam logic [FSR_W-1:0] TT_MASK = {{(FSR_W-TT_W){1'b0}}, {TT_W{1'b1}}} << TT_LSB;

    // flag order: invalid is the MSB, inexact the LSB
    typedef struct packed {
        logic nv;
        logic of;
        logic uf;
        logic dz;
        logic nx;
    } exc_t;

    typedef enum logic [RND_W-1:0] {
        RF_NEAREST = 2'd0,
        RF_ZERO    = 2'd1,
        RF_UP      = 2'd2,
        RF_DOWN    = 2'd3
    } rnd_field_e;

    typedef struct packed {
        logic trap;
        exc_t cexc;
        exc_t aexc;
    } eval_t;

    function automatic exc_t take_exc(input logic [FSR_W-1:0] w, input int lsb);
        return exc_t'(w[lsb +: NFLAG]);
    endfunction
endpackage

// File: rtl/fsr_exc_eval.sv
module fsr_exc_eval
    import fsr_pkg::*;
(
    input  exc_t              flags,
    input  logic [FSR_W-1:0]  cur,
    output eval_t             res
);
    logic [NFLAG-1:0] hit;
    exc_t             acc_old;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_hit
            assign hit[i] = flags[i] & cur[TEN_LSB + i];
        end
    endgenerate

    always_comb begin
        acc_old  = take_exc(cur, AEXC_LSB);
        res.trap = |hit;
        res.cexc = flags;
        res.aexc = res.trap ? acc_old : exc_t'(acc_old | flags);
    end
endmodule

// File: rtl/fsr_round_dec.sv
module fsr_round_dec
    import fsr_pkg::*;
(
    input  logic [RND_W-1:0] field,
    output logic [NMODE-1:0] sel
);
    always_comb begin
        sel = '0;
        case (rnd_field_e'(field))
            RF_NEAREST: sel[0] = 1'b1;
            RF_UP:      sel[2] = 1'b1;
            RF_DOWN:    sel[3] = 1'b1;
            default:    sel[1] = 1'b1; // toward zero
        endcase
    end
endmodule

// File: rtl/fsr_trap_unit.sv
module fsr_trap_unit
    import fsr_pkg::*;
#(
    parameter logic [31:0] WR_MASK = 32'hCF80_03FF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [4:0]  op_flags,
    input  logic        ld_valid,
    input  logic [31:0] ld_data,
    output logic [31:0] status,
    output logic        trap_req,
    output logic [3:0]  rnd_sel
);
    localparam logic [FSR_W-1:0] KEEP_MASK = ~WR_MASK & ~TT_MASK;
    localparam logic [FSR_W-1:0] LOAD_MASK = WR_MASK & ~TT_MASK;

    logic             op_take;
    eval_t            ev;
    logic [FSR_W-1:0] st_q;
    logic [FSR_W-1:0] st_d;

    assign op_take = op_valid & ~ld_valid;

    fsr_exc_eval u_eval (
        .flags (exc_t'(op_flags)),
        .cur   (st_q),
        .res   (ev)
    );

    always_comb begin
        st_d = st_q;
        if (ld_valid) begin
            st_d = (ld_data & LOAD_MASK) | (st_q & KEEP_MASK);
        end else if (op_valid) begin
            st_d[CEXC_LSB +: NFLAG] = ev.cexc;
            st_d[AEXC_LSB +: NFLAG] = ev.aexc;
            if (ev.trap) st_d[TT_LSB +: TT_W] = TT_IEEE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            trap_req <= 1'b0;
        end else begin
            st_q     <= st_d;
            trap_req <= op_take & ev.trap;
        end
    end

    assign status = st_q;

    fsr_round_dec u_rnd (
        .field (st_q[RND_LSB +: RND_W]),
        .sel   (rnd_sel)
    );

    AST_CEXC_TAKEN: assert property (@(posedge clk) disable iff (rst)
        op_valid && !ld_valid |=> status[4:0] == $past(op_flags)); // R2
    AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && trap_req |-> $past(op_valid && !ld_valid && (op_flags & status[27:23]) != 0)); // R3
    AST_TRAP_TYPE: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> status[16:14] == 3'b001); // R3
    AST_ACCR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && trap_req |-> status[9:5] == $past(status[9:5])); // R4
    AST_ACCR_MERGE: assert property (@(posedge clk) disable iff (rst)
        op_valid && !ld_valid && (op_flags & status[27:23]) == 0
        |=> status[9:5] == ($past(status[9:5]) | $past(op_flags))); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> !trap_req && status[16:14] == 3'b000); // R9
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !op_valid && !ld_valid |=> $stable(status)); // R10
    AST_RND_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(rnd_sel)); // R8
endmodule

// File: tb/test_fsr_trap_unit.sv
`timescale 1ns/1ps
module test_fsr_trap_unit;
    localparam logic [31:0] MSK = 32'hCF80_03FF;
    localparam logic [31:0] TTM = 32'h0001_C000;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [4:0]  op_flags;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic [31:0] status;
    logic        trap_req;
    logic [3:0]  rnd_sel;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_st;
    logic        m_trap;

    always #2 clk = ~clk;

    fsr_trap_unit i_fsr_trap_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
        .ld_valid(ld_valid), .ld_data(ld_data),
        .status(status), .trap_req(trap_req), .rnd_sel(rnd_sel)
    );

    function automatic logic [3:0] exp_rnd(input logic [31:0] s);
        return 4'b0001 << s[31:30];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model(input bit ov, input logic [4:0] fl, input bit lv, input logic [31:0] d);
        logic [4:0] hit;
        m_trap = 1'b0;
        if (lv) begin
            m_st = (d & MSK & ~TTM) | (m_st & ~MSK & ~TTM);
        end else if (ov) begin
            hit = fl & m_st[27:23];
            m_st[4:0] = fl;
            if (hit != 0) begin
                m_st[16:14] = 3'b001;
                m_trap = 1'b1;
            end else begin
                m_st[9:5] = m_st[9:5] | fl;
            end
        end
    endtask

    task automatic step(input string tag, input bit ov, input logic [4:0] fl,
                        input bit lv, input logic [31:0] d);
        @(negedge clk);
        op_valid = ov; op_flags = fl; ld_valid = lv; ld_data = d;
        model(ov, fl, lv, d);
        @(negedge clk);
        op_valid = 1'b0; ld_valid = 1'b0;
        chk({tag, " status"}, status, m_st);
        chk({tag, " trap_req"}, {31'd0, trap_req}, {31'd0, m_trap});
        chk({tag, " rnd_sel"}, {28'd0, rnd_sel}, {28'd0, exp_rnd(m_st)});
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] acc_before;
        void'($urandom(32'd1234));
        rst = 1'b1; op_valid = 1'b0; op_flags = '0; ld_valid = 1'b0; ld_data = '0;
        m_st = '0; m_trap = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 status", status, 32'h0);
        chk("R1 trap_req", {31'd0, trap_req}, 32'd0);
        chk("R1 rnd_sel", {28'd0, rnd_sel}, 32'h1);

        step("R2 R5 inexact", 1'b1, 5'b00001, 1'b0, '0);
        step("R2 R5 overflow", 1'b1, 5'b01000, 1'b0, '0);
        chk("R5 accrued", {27'd0, status[9:5]}, 32'h09);
        step("R10 zero flags", 1'b1, 5'b00000, 1'b0, '0);
        chk("R10 cexc cleared", {27'd0, status[4:0]}, 32'h0);
        step("R10 idle", 1'b0, 5'b11111, 1'b0, '0);

        // enable divide-by-zero (bit 24) and invalid (bit 27)
        step("R7 load enables", 1'b0, '0, 1'b1, 32'h0900_0000 | (32'h3 << 5));
        acc_before = status;
        step("R3 R4 trap dz", 1'b1, 5'b00011, 1'b0, '0);
        chk("R4 accrued kept", {27'd0, status[9:5]}, {27'd0, acc_before[9:5]});
        chk("R3 trap type", {29'd0, status[16:14]}, 32'd1);
        step("R3 pulse ends", 1'b0, '0, 1'b0, '0);
        chk("R3 trap low", {31'd0, trap_req}, 32'd0);
        step("R6 hold through op", 1'b1, 5'b00100, 1'b0, '0);
        chk("R6 tt held", {29'd0, status[16:14]}, 32'd1);
        step("R3 back-to-back a", 1'b1, 5'b10000, 1'b0, '0);
        step("R3 back-to-back b", 1'b1, 5'b00010, 1'b0, '0);
        step("R9 collide", 1'b1, 5'b11111, 1'b1, 32'hFFFF_FFFF);
        chk("R7 R6 all-ones load", status, MSK);

        for (int m = 0; m < 4; m++) begin
            step("R8 mode", 1'b0, '0, 1'b1, 32'(m) << 30);
        end

        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            bit ov, lv;
            string tag;
            r  = $urandom;
            lv = (r[2:0] == 3'd0);
            ov = (r[4:3] != 2'd0);
            if (lv)                              tag = "R7 R9 rnd load";
            else if (ov && ((r[9:5] & m_st[27:23]) != 0)) tag = "R3 R4 rnd trap";
            else if (ov)                         tag = "R2 R5 rnd op";
            else                                 tag = "R10 R6 rnd idle";
            step(tag, ov, r[9:5], lv, $urandom);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule